// File: doc/BRIEF.md
# Set/Clear Control and Status Register

This block holds four on/off control functions for a counting board: a user indicator LED, a 25 MHz test pulse source, a counter test mode and a 50 MHz reference pulser. Software writes a 32-bit word. Each function has a pair of bits in that word. A 1 in the low-half bit switches the function on. A 1 in the bit sixteen places higher switches it off. A 0 in either bit leaves the function alone. Software can therefore change one function without reading the register first and without disturbing the others.

A read returns a status word, and its layout differs from the write layout. The held state of the four functions sits in their enable positions. Mode, overflow, external input and external latch flags, which arrive on input ports, fill the upper half. Every other bit reads 0. Read data is registered and appears one cycle after the read strobe. The four held states also drive individual output pins.

When a single write sets both the enable bit and the disable bit of the same function, the function toggles. This is the fixed behaviour chosen for that case.

Top module: `jk_ctrl_status_reg`

## Requirements
- R1: A write with a 1 in bit 0, 4, 5 or 6 (and a 0 in the bit 16 places higher) turns on the LED, test pulse, counter test or reference pulser function at that clock edge. The matching output pin is 1 after the edge.
- R2: A write with a 1 in bit 16, 20, 21 or 22 (and a 0 in the enable bit 16 places lower) turns the matching function off at that clock edge.
- R3: A function whose bit pair is 00 in a write keeps its state. Bits outside the eight pair positions have no effect on any function.
- R4: A write with both bits of one pair set inverts that function's state.
- R5: While rst is high, all four functions are off and rd_data is 0x00000000.
- R6: A read (rd_en high at an edge) loads rd_data at that edge with the function states in bits 0, 4, 5 and 6. Those states are the values held before any write sampled at the same edge.
- R7: The read word carries the status inputs: scaler enabled in bit 16, sequential mode in bit 18, memory test in bit 23, armed in bit 24, auxiliary mode in bit 25 and overflow in bit 27.
- R8: The read word carries ext_in[0] in bit 28, ext_in[1] in bit 29, ext_latch[0] in bit 30 and ext_latch[1] in bit 31.
- R9: Read bits 1–3, 7–15, 17, 19–22 and 26 are always 0.
- R10: rd_data keeps its value in every cycle in which rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Set/clear write word |
| rd_data | output | 32 | Registered status word |
| st_scaler_en | input | 1 | Scaler operation enabled flag |
| st_seq_en | input | 1 | Sequential counting mode flag |
| st_memtest_en | input | 1 | Memory test mode flag |
| st_armed | input | 1 | Operation armed flag |
| st_aux_en | input | 1 | Auxiliary mode flag |
| st_overflow | input | 1 | Overflow flag |
| ext_in | input | 2 | External input levels |
| ext_latch | input | 2 | External latch levels |
| led_on | output | 1 | User LED control |
| tpulse_on | output | 1 | 25 MHz test pulse enable |
| ctest_on | output | 1 | Counter test mode enable |
| refpulse_on | output | 1 | 50 MHz reference pulser enable |

## Verification
A wrong held state shows on the function's own output pin at the first edge after the faulty write. It also appears in the next read word one cycle after the read strobe. If the set and clear bits were swapped or misaligned, a single write would light the wrong pin or none at all. An error in the toggle case only shows when both bits of a pair are written together. Misplaced status bits appear in the first read after an input changes. A read that samples state after the write instead of before it differs only when a read and a write share a cycle, so the bench drives that case on purpose.

// File: rtl/jkcsr_pkg.sv
package jkcsr_pkg;
  localparam int DATA_W  = 32;
  localparam int CLR_OFS = 16;
  localparam int NUM_FN  = 4;

  // Enable bit position of each controlled function; order fixes output pins.
  function automatic int fn_pos(input int i);
    case (i)
      0:       return 0;   // LED
      1:       return 4;   // test pulses
      2:       return 5;   // counter test
      default: return 6;   // reference pulser
    endcase
  endfunction

  localparam int B_SCALER  = 16;
  localparam int B_SEQ     = 18;
  localparam int B_MEMTEST = 23;
  localparam int B_ARMED   = 24;
  localparam int B_AUX     = 25;
  localparam int B_OVF     = 27;
  localparam int B_EXTIN   = 28;
  localparam int B_LATCH   = 30;

  typedef struct packed {
    logic [1:0] latch;
    logic [1:0] ext;
    logic       ovf;
    logic       aux;
    logic       armed;
    logic       memtest;
    logic       seq;
    logic       scaler;
  } status_t;

  function automatic logic [DATA_W-1:0] used_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_FN; i++) m[fn_pos(i)] = 1'b1;
    m[B_SCALER] = 1'b1; m[B_SEQ] = 1'b1; m[B_MEMTEST] = 1'b1;
    m[B_ARMED] = 1'b1;  m[B_AUX] = 1'b1; m[B_OVF] = 1'b1;
    m[B_EXTIN +: 2] = 2'b11; m[B_LATCH +: 2] = 2'b11;
    return m;
  endfunction
endpackage

// File: rtl/jk_bit_cell.sv
module jk_bit_cell (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else if (wr_en) begin
      case ({set_i, clr_i})
        2'b10:   q <= 1'b1;
        2'b01:   q <= 1'b0;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end

  a_r1_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && set_i && !clr_i) |=> q);
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && clr_i && !set_i) |=> !q);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (set_i || clr_i)) |=> $stable(q));
  a_r4_toggle: assert property (@(posedge clk) disable iff (rst)
    (wr_en && set_i && clr_i) |=> (q != $past(q)));
endmodule

// File: rtl/csr_readback.sv
module csr_readback
  import jkcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [NUM_FN-1:0] ctrl,
  input  status_t           st,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] USED = used_mask();

  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_FN; i++) word[fn_pos(i)] = ctrl[i];
    word[B_SCALER]     = st.scaler;
    word[B_SEQ]        = st.seq;
    word[B_MEMTEST]    = st.memtest;
    word[B_ARMED]      = st.armed;
    word[B_AUX]        = st.aux;
    word[B_OVF]        = st.ovf;
    word[B_EXTIN +: 2] = st.ext;
    word[B_LATCH +: 2] = st.latch;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= word;
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  a_r9_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ((rd_data & ~USED) == '0));
  a_r8_ext: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data[B_EXTIN +: 2] == $past(st.ext)));

  for (genvar g = 0; g < NUM_FN; g++) begin : g_chk
    a_r6_state: assert property (@(posedge clk) disable iff (rst)
      rd_en |=> (rd_data[fn_pos(g)] == $past(ctrl[g])));
  end
endmodule

// File: rtl/jk_ctrl_status_reg.sv
module jk_ctrl_status_reg
  import jkcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              st_scaler_en,
  input  logic              st_seq_en,
  input  logic              st_memtest_en,
  input  logic              st_armed,
  input  logic              st_aux_en,
  input  logic              st_overflow,
  input  logic [1:0]        ext_in,
  input  logic [1:0]        ext_latch,
  output logic              led_on,
  output logic              tpulse_on,
  output logic              ctest_on,
  output logic              refpulse_on
);
  logic [NUM_FN-1:0] ctrl;
  status_t           st;

  for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
    jk_bit_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_en),
      .set_i (wr_data[fn_pos(g)]),
      .clr_i (wr_data[fn_pos(g) + CLR_OFS]),
      .q     (ctrl[g])
    );
  end

  always_comb begin
    st.scaler  = st_scaler_en;
    st.seq     = st_seq_en;
    st.memtest = st_memtest_en;
    st.armed   = st_armed;
    st.aux     = st_aux_en;
    st.ovf     = st_overflow;
    st.ext     = ext_in;
    st.latch   = ext_latch;
  end

  csr_readback u_rb (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .ctrl    (ctrl),
    .st      (st),
    .rd_data (rd_data)
  );

  assign led_on      = ctrl[0];
  assign tpulse_on   = ctrl[1];
  assign ctest_on    = ctrl[2];
  assign refpulse_on = ctrl[3];

  a_r5_reset: assert property (@(posedge clk)
    rst |=> (ctrl == '0 && rd_data == '0));
endmodule

// File: tb/test_jk_ctrl_status_reg.sv
module test_jk_ctrl_status_reg;
  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic sc = 0, sq = 0, mt = 0, ar = 0, ax = 0, ov = 0;
  logic [1:0] ei = 0, el = 0;
  logic led_on, tpulse_on, ctest_on, refpulse_on;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  jk_ctrl_status_reg i_jk_ctrl_status_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .rd_data(rd_data), .st_scaler_en(sc), .st_seq_en(sq), .st_memtest_en(mt),
    .st_armed(ar), .st_aux_en(ax), .st_overflow(ov), .ext_in(ei),
    .ext_latch(el), .led_on(led_on), .tpulse_on(tpulse_on),
    .ctest_on(ctest_on), .refpulse_on(refpulse_on));

  logic [3:0] m = 0;               // model of LED, test pulse, counter test, ref pulser
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic fire = 0;

  function automatic int pos(input int i);
    return (i == 0) ? 0 : i + 3;
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w = 0;
    for (int i = 0; i < 4; i++) w[pos(i)] = m[i];
    w[16] = sc; w[18] = sq; w[23] = mt; w[24] = ar; w[25] = ax; w[27] = ov;
    w[29:28] = ei; w[31:30] = el;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one bus cycle; pushes expected read word, updates model, checks pins.
  task automatic op(input bit w, input bit r, input logic [31:0] d, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d;
    if (r) begin exp_q.push_back(exp_word()); tag_q.push_back(tag); end
    if (w)
      for (int i = 0; i < 4; i++) begin
        case ({d[pos(i)], d[pos(i) + 16]})
          2'b10: m[i] = 1'b1;
          2'b01: m[i] = 1'b0;
          2'b11: m[i] = ~m[i];
          default: ;
        endcase
      end
    @(negedge clk);
    wr_en = 0; rd_en = 0; wr_data = 0;
    chk(tag, {28'd0, refpulse_on, ctest_on, tpulse_on, led_on}, {28'd0, m});
  endtask

  // Monitor: compare each completed read with the queue front.
  always @(posedge clk) fire <= rd_en;
  always @(negedge clk)
    if (fire && exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());

  logic [31:0] held;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5 rd_data", rd_data, 32'h0);
    chk("R5 pins", {28'd0, refpulse_on, ctest_on, tpulse_on, led_on}, 32'h0);
    rst = 0;
    op(0, 1, 0, "R5 first read");
    op(1, 0, 32'h0000_0001, "R1 led on");
    op(1, 0, 32'h0000_0070, "R1 three on");
    op(0, 1, 0, "R6 read all on");
    op(1, 0, 32'h0001_0000, "R2 led off");
    op(1, 0, 32'h0020_0000, "R2 ctest off");
    op(0, 1, 0, "R6 read mixed");
    op(1, 0, 32'hFF80_FF8E, "R3 unused bits");
    op(1, 0, 32'h0000_0000, "R3 zero write");
    op(0, 1, 0, "R3 readback");
    op(1, 0, 32'h0011_0011, "R4 toggle led+tp");
    op(1, 0, 32'h0040_0040, "R4 toggle ref");
    op(0, 1, 0, "R4 readback");
    op(1, 1, 32'h0000_0071, "R6 read with write");
    op(0, 1, 0, "R6 after write");
    sc = 1; ar = 1; ov = 1; ei = 2'b01; el = 2'b10;
    op(0, 1, 0, "R7 R8 status a");
    sc = 0; ar = 0; ov = 0; sq = 1; mt = 1; ax = 1; ei = 2'b10; el = 2'b01;
    op(0, 1, 0, "R7 R8 status b");
    sq = 0; mt = 0; ax = 0; ei = 0; el = 0;
    op(1, 0, 32'h0071_0000, "R2 all off");
    op(0, 1, 0, "R9 zero bits");
    @(negedge clk);
    held = rd_data;
    sc = 1; ei = 2'b11;
    op(1, 0, 32'h0000_0010, "R10 no read");
    chk("R10 hold", rd_data, held);
    repeat (2) @(negedge clk);
    chk("R9 queue drained", {31'd0, exp_q.size() != 0}, 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule